// File: doc/BRIEF.md
# Dual Down-Counter With Watchdog Mode

Two 32-bit down-counters share one register bus. Channel 0 is a plain interval timer. Each channel has a reload value, a live count, a control word with an 8-bit prescaler, and a sticky zero flag. A channel can run once and stop at zero, or reload and run again. Its interrupt is the zero flag gated by an interrupt-enable bit.

Channel 1 has the same registers plus a watchdog mode. In that mode, reaching zero gives a one-cycle reset request instead of an interrupt, and sets a reset-cause flag. That flag survives the reset request. Software enters watchdog mode with one bit write. Software can leave it only by writing two fixed key words, in order and back to back, to a write-only disarm register.

A shared clock enable, `tick_en`, paces both prescalers. Routing of the interrupts and the reset request lies outside the block.

Top module: `dual_down_timer`

## Requirements
- R1: After reset every readable register reads 0 and `tmr_irq`, `wdt_irq` and `rst_req` are low. Timer registers sit at byte offsets 0x00–0x0F and watchdog registers at 0x20–0x37, each word being reload (+0x00), count (+0x04), control (+0x08), flag (+0x0C), cause (+0x10, channel 1 only) and disarm (+0x14, channel 1 only).
- R2: Writing the reload register also loads the count on the same edge. With auto-reload on (control bit 1), a reload value N gives successive zero arrivals exactly (N+1)·(P+1) enabled cycles apart, where P is the prescaler in control bits 15:8.
- R3: With auto-reload off, the count stays at zero once it arrives and no further zero event occurs.
- R4: The count steps only on cycles with `tick_en` high and the run bit (control bit 0) set, once every P+1 such cycles. With `tick_en` low the count holds.
- R5: A zero arrival outside watchdog mode sets flag bit 0. Writing 1 to flag bit 0 clears it. A channel interrupt is high exactly while its flag is set and its enable bit (control bit 2) is set. It appears right after the edge on which the count becomes zero.
- R6: With watchdog mode (channel 1 control bit 3) set, the enable bit is ignored and `wdt_irq` stays low. A zero arrival pulses `rst_req` for one cycle, on the cycle after the count becomes zero. It also sets cause bit 0 and leaves flag bit 0 unchanged.
- R7: Writing 0x12345678 and then 0x87654321 to the disarm register, with no bus write in between, clears watchdog mode.
- R8: A control write with bit 3 equal to 0 does not clear watchdog mode. A key sequence broken by any other bus write, or the second key written alone, does not clear it either.
- R9: Writing the value 1 to the disarm register sets watchdog mode.
- R10: Cause bit 0 is unaffected by the reset request and by writing 0 to it. It clears only on power-on reset or when 1 is written to it.
- R11: The disarm register reads 0. Control bit 3 of the timer channel reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| tick_en | input | 1 | Count clock enable shared by both channels |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| tmr_irq | output | 1 | Timer channel interrupt |
| wdt_irq | output | 1 | Watchdog channel interrupt (timer mode only) |
| rst_req | output | 1 | One-cycle reset request from watchdog mode |

## Verification
A register write takes effect on the rising edge that samples it, and a read returns the current register value in the same cycle. When the count becomes zero on an edge, the flag and any interrupt show right after that edge. The reset request is registered and is high during the cycle that follows. The bench drives and samples on falling edges and counts the rising edges between a write and each sample. For example, after loading 3 and starting, the interrupt must still be low at the second falling edge and high at the third, and the reset request must be high only at the third. Prescaled periods are measured edge by edge against (N+1)·(P+1).

// File: rtl/ddt_pkg.sv
package ddt_pkg;
   localparam int PRE_W = 8;

   localparam logic [2:0] IDX_LOAD   = 3'd0;
   localparam logic [2:0] IDX_COUNT  = 3'd1;
   localparam logic [2:0] IDX_CTRL   = 3'd2;
   localparam logic [2:0] IDX_FLAG   = 3'd3;
   localparam logic [2:0] IDX_CAUSE  = 3'd4;
   localparam logic [2:0] IDX_DISARM = 3'd5;

   typedef struct packed {
      logic [PRE_W-1:0] presc;
      logic             wdog;
      logic             ien;
      logic             auto_rl;
      logic             run;
   } ctrl_t;

   // Control word layout as seen on the bus (low 16 bits).
   function automatic logic [15:0] ctrl_to_word(ctrl_t c);
      return {c.presc, 4'h0, c.wdog, c.ien, c.auto_rl, c.run};
   endfunction
endpackage

// File: rtl/ddt_core.sv
module ddt_core #(
   parameter int CNT_W = 32,
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             run,
   input  logic             auto_rl,
   input  logic [PRE_W-1:0] presc,
   input  logic             load_wr,
   input  logic [CNT_W-1:0] load_new,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count,
   output logic             zero_evt
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [PRE_W-1:0] pre_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;
   logic             active;
   logic             step;
   logic             at_zero;
   logic             at_one;

   assign active  = run && tick_en;
   assign step    = active && (pre_q >= presc);
   assign at_zero = (cnt_q == '0);
   assign at_one  = (cnt_q == ONE);

   always_comb begin
      if (!at_zero)     cnt_nxt = cnt_q - ONE;
      else if (auto_rl) cnt_nxt = load_val;
      else              cnt_nxt = cnt_q;
   end

   // A step that lands on zero, including a zero reload value re-arriving.
   assign zero_evt = step && (at_one || (at_zero && auto_rl && (load_val == '0)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         cnt_q <= '0;
      end else if (load_wr) begin
         pre_q <= '0;
         cnt_q <= load_new;
      end else if (active) begin
         if (step) begin
            pre_q <= '0;
            cnt_q <= cnt_nxt;
         end else begin
            pre_q <= pre_q + 1'b1;
         end
      end
   end

   assign count = cnt_q;
endmodule

// File: rtl/ddt_unlock.sv
module ddt_unlock #(
   parameter int                DATA_W   = 32,
   parameter logic [DATA_W-1:0] KEY_A    = DATA_W'(32'h1234_5678),
   parameter logic [DATA_W-1:0] KEY_B    = DATA_W'(32'h8765_4321),
   parameter logic [DATA_W-1:0] ARM_WORD = DATA_W'(1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              any_wr,
   input  logic              dis_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              arm,
   output logic              disarm
);
   logic half_q;

   // Every bus write re-decides the half-done state; only the first key arms it.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      half_q <= 1'b0;
      else if (any_wr) half_q <= dis_wr && (wdata == KEY_A);
   end

   assign disarm = dis_wr && half_q && (wdata == KEY_B);
   assign arm    = dis_wr && (wdata == ARM_WORD);
endmodule

// File: rtl/ddt_channel.sv
module ddt_channel
   import ddt_pkg::*;
#(
   parameter int                DATA_W   = 32,
   parameter int                CNT_W    = 32,
   parameter bit                WDOG_CAP = 1'b0,
   parameter logic [DATA_W-1:0] KEY_A    = DATA_W'(32'h1234_5678),
   parameter logic [DATA_W-1:0] KEY_B    = DATA_W'(32'h8765_4321),
   parameter logic [DATA_W-1:0] ARM_WORD = DATA_W'(1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              any_wr,
   input  logic              ch_wr,
   input  logic [2:0]        reg_idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output ctrl_t             ctrl_o,
   output logic [CNT_W-1:0]  count_o,
   output logic              irq,
   output logic              rst_req
);
   localparam int CTL_PRE_LSB = 8;

   logic [CNT_W-1:0] load_q;
   ctrl_t            ctrl_q;
   logic             flag_q;
   logic             cause_q;
   logic             rst_q;
   logic             wd_nxt;
   logic             arm;
   logic             disarm;
   logic             zero_evt;
   logic [CNT_W-1:0] count;
   logic             wr_load, wr_ctrl, wr_flag, wr_cause, wr_dis;

   assign wr_load  = ch_wr && (reg_idx == IDX_LOAD);
   assign wr_ctrl  = ch_wr && (reg_idx == IDX_CTRL);
   assign wr_flag  = ch_wr && (reg_idx == IDX_FLAG);
   assign wr_cause = ch_wr && (reg_idx == IDX_CAUSE);
   assign wr_dis   = ch_wr && (reg_idx == IDX_DISARM);

   ddt_core #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .run      (ctrl_q.run),
      .auto_rl  (ctrl_q.auto_rl),
      .presc    (ctrl_q.presc),
      .load_wr  (wr_load),
      .load_new (wdata[CNT_W-1:0]),
      .load_val (load_q),
      .count    (count),
      .zero_evt (zero_evt)
   );

   generate
      if (WDOG_CAP) begin : g_wd
         ddt_unlock #(
            .DATA_W(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B), .ARM_WORD(ARM_WORD)
         ) u_unlock (
            .clk    (clk),
            .rst_n  (rst_n),
            .any_wr (any_wr),
            .dis_wr (wr_dis),
            .wdata  (wdata),
            .arm    (arm),
            .disarm (disarm)
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cause_q <= 1'b0;
               rst_q   <= 1'b0;
            end else begin
               if (zero_evt && ctrl_q.wdog)   cause_q <= 1'b1;
               else if (wr_cause && wdata[0]) cause_q <= 1'b0;
               rst_q <= zero_evt && ctrl_q.wdog && !rst_q;
            end
         end

         always_comb begin
            wd_nxt = ctrl_q.wdog;
            if (wr_ctrl && wdata[3]) wd_nxt = 1'b1;
            if (arm)                 wd_nxt = 1'b1;
            if (disarm)              wd_nxt = 1'b0;
         end
      end else begin : g_tmr
         assign arm     = 1'b0;
         assign disarm  = 1'b0;
         assign cause_q = 1'b0;
         assign rst_q   = 1'b0;
         assign wd_nxt  = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_q <= '0;
         ctrl_q <= '0;
         flag_q <= 1'b0;
      end else begin
         if (wr_load) load_q <= wdata[CNT_W-1:0];
         if (wr_ctrl) begin
            ctrl_q.run     <= wdata[0];
            ctrl_q.auto_rl <= wdata[1];
            ctrl_q.ien     <= wdata[2];
            ctrl_q.presc   <= wdata[CTL_PRE_LSB +: PRE_W];
         end
         ctrl_q.wdog <= wd_nxt;
         if (zero_evt && !ctrl_q.wdog) flag_q <= 1'b1;
         else if (wr_flag && wdata[0]) flag_q <= 1'b0;
      end
   end

   always_comb begin
      case (reg_idx)
         IDX_LOAD:  rdata = DATA_W'(load_q);
         IDX_COUNT: rdata = DATA_W'(count);
         IDX_CTRL:  rdata = DATA_W'(ctrl_to_word(ctrl_q));
         IDX_FLAG:  rdata = DATA_W'(flag_q);
         IDX_CAUSE: rdata = DATA_W'(cause_q);
         default:   rdata = '0;
      endcase
   end

   assign ctrl_o  = ctrl_q;
   assign count_o = count;
   assign irq     = flag_q && ctrl_q.ien && !ctrl_q.wdog;
   assign rst_req = rst_q;
endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer
   import ddt_pkg::*;
#(
   parameter int                ADDR_W   = 6,
   parameter int                DATA_W   = 32,
   parameter int                CNT_W    = 32,
   parameter logic [DATA_W-1:0] KEY_A    = DATA_W'(32'h1234_5678),
   parameter logic [DATA_W-1:0] KEY_B    = DATA_W'(32'h8765_4321),
   parameter logic [DATA_W-1:0] ARM_WORD = DATA_W'(1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              tmr_irq,
   output logic              wdt_irq,
   output logic              rst_req
);
   localparam int NUM_CH  = 2;
   localparam int IDX_LSB = 2;
   localparam int IDX_W   = 3;
   localparam int CH_BIT  = IDX_LSB + IDX_W;

   generate
      if (ADDR_W < CH_BIT + 1) begin : g_bad_addr
         $error("ADDR_W too small for two register windows");
      end
      if (DATA_W < 16) begin : g_bad_data
         $error("DATA_W must hold the 16-bit control word");
      end
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W must lie between 2 and DATA_W");
      end
   endgenerate

   logic              hi_ok;
   logic              any_wr;
   logic              ch_sel;
   logic [IDX_W-1:0]  reg_idx;
   logic [DATA_W-1:0] ch_rdata [NUM_CH];
   ctrl_t             ch_ctrl  [NUM_CH];
   logic [CNT_W-1:0]  ch_count [NUM_CH];
   logic              ch_irq   [NUM_CH];
   logic              ch_rst   [NUM_CH];
   ctrl_t             tmr_ctrl, wd_ctrl;
   logic [CNT_W-1:0]  tmr_count;

   generate
      if (ADDR_W > CH_BIT + 1) begin : g_hi
         assign hi_ok = (bus_addr[ADDR_W-1:CH_BIT+1] == '0);
      end else begin : g_nohi
         assign hi_ok = 1'b1;
      end
   endgenerate

   assign any_wr  = bus_sel && bus_we;
   assign ch_sel  = bus_addr[CH_BIT];
   assign reg_idx = bus_addr[CH_BIT-1:IDX_LSB];

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         ddt_channel #(
            .DATA_W   (DATA_W),
            .CNT_W    (CNT_W),
            .WDOG_CAP (i == NUM_CH - 1),
            .KEY_A    (KEY_A),
            .KEY_B    (KEY_B),
            .ARM_WORD (ARM_WORD)
         ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_en (tick_en),
            .any_wr  (any_wr),
            .ch_wr   (any_wr && hi_ok && (ch_sel == 1'(i))),
            .reg_idx (reg_idx),
            .wdata   (bus_wdata),
            .rdata   (ch_rdata[i]),
            .ctrl_o  (ch_ctrl[i]),
            .count_o (ch_count[i]),
            .irq     (ch_irq[i]),
            .rst_req (ch_rst[i])
         );
      end
   endgenerate

   assign bus_rdata = (bus_sel && hi_ok) ? ch_rdata[ch_sel] : '0;
   assign tmr_irq   = ch_irq[0];
   assign wdt_irq   = ch_irq[1];
   assign rst_req   = ch_rst[1] || ch_rst[0];

   assign tmr_ctrl  = ch_ctrl[0];
   assign wd_ctrl   = ch_ctrl[1];
   assign tmr_count = ch_count[0];
endmodule

// File: rtl/ddt_checker.sv
module ddt_checker
   import ddt_pkg::*;
#(
   parameter int                ADDR_W   = 6,
   parameter int                DATA_W   = 32,
   parameter int                CNT_W    = 32,
   parameter logic [DATA_W-1:0] KEY_B    = DATA_W'(32'h8765_4321),
   parameter logic [DATA_W-1:0] ARM_WORD = DATA_W'(1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              tmr_irq,
   input logic              wdt_irq,
   input logic              rst_req,
   input ctrl_t             tmr_ctrl,
   input ctrl_t             wd_ctrl,
   input logic [CNT_W-1:0]  tmr_count
);
   localparam logic [ADDR_W-1:0] A_TMR_LOAD = ADDR_W'(6'h00);
   localparam logic [ADDR_W-1:0] A_WD_DIS   = ADDR_W'(6'h34);

   logic wr_now;
   assign wr_now = bus_sel && bus_we;

   AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req); // R6

   AST_RST_FROM_WDOG: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $past(wd_ctrl.wdog)); // R6

   AST_WDT_QUIET_IN_WDOG: assert property (@(posedge clk) disable iff (!rst_n)
      wd_ctrl.wdog |-> !wdt_irq); // R6

   AST_TMR_IRQ_NEEDS_IEN: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_irq |-> tmr_ctrl.ien); // R5

   AST_WDOG_EXIT_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wd_ctrl.wdog) |-> $past(wr_now && bus_addr == A_WD_DIS && bus_wdata == KEY_B)); // R7

   AST_ARM_WORD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_now && bus_addr == A_WD_DIS && bus_wdata == ARM_WORD) |=> wd_ctrl.wdog); // R9

   AST_ONESHOT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_count == '0 && !tmr_ctrl.auto_rl && !(wr_now && bus_addr == A_TMR_LOAD))
      |=> tmr_count == '0); // R3
endmodule

bind dual_down_timer ddt_checker #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .KEY_B(KEY_B), .ARM_WORD(ARM_WORD)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .tmr_irq   (tmr_irq),
   .wdt_irq   (wdt_irq),
   .rst_req   (rst_req),
   .tmr_ctrl  (tmr_ctrl),
   .wd_ctrl   (wd_ctrl),
   .tmr_count (tmr_count)
);

// File: tb/sim_dual_down_timer.sv
`timescale 1ns/1ps
module sim_dual_down_timer;
   localparam logic [5:0] T_LOAD = 6'h00, T_CNT = 6'h04, T_CTL = 6'h08, T_FLAG = 6'h0C;
   localparam logic [5:0] W_LOAD = 6'h20, W_CTL = 6'h28, W_FLAG = 6'h2C;
   localparam logic [5:0] W_CAUSE = 6'h30, W_DIS = 6'h34;
   localparam logic [31:0] KA = 32'h1234_5678, KB = 32'h8765_4321;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b1;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tmr_irq, wdt_irq, rst_req;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   dual_down_timer u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tmr_irq(tmr_irq), .wdt_irq(wdt_irq), .rst_req(rst_req)
   );

   function automatic int exp_period(int n, int p);
      return (n + 1) * (p + 1);
   endfunction

   function automatic logic [31:0] ctl_word(bit run, bit arl, bit ien, bit wd, int p);
      return {16'h0, 8'(p), 4'h0, wd, ien, arl, run};
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(logic [5:0] a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(logic [5:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #0.5 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic expect_reg(string tag, logic [5:0] a, logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      check(tag, v, exp);
   endtask

   // Edges between two successive arrivals of the timer count at zero.
   task automatic meas(output int per);
      logic [31:0] prev, cur;
      int t0;
      bit got;
      per = -1; t0 = 0; got = 1'b0;
      rd(T_CNT, prev);
      for (int t = 1; t < 600; t++) begin
         @(negedge clk);
         rd(T_CNT, cur);
         if (prev != 0 && cur == 0) begin
            if (!got) begin got = 1'b1; t0 = t; end
            else begin per = t - t0; break; end
         end
         prev = cur;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog timeout actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int per, pulses, pulse_at, wirq_seen;
      logic [31:0] v;
      void'($urandom(32'd7741));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      expect_reg("R1 tmr load", T_LOAD, 0);
      expect_reg("R1 tmr count", T_CNT, 0);
      expect_reg("R1 tmr ctl", T_CTL, 0);
      expect_reg("R1 wd ctl", W_CTL, 0);
      expect_reg("R1 wd cause", W_CAUSE, 0);
      check("R1 outputs", {29'd0, tmr_irq, wdt_irq, rst_req}, 0);

      // R2 reload on write, R4 prescaled period, random
      for (int k = 0; k < 6; k++) begin
         int n, p;
         n = $urandom_range(20, 1);
         p = $urandom_range(3, 0);
         wr(T_CTL, 0);
         wr(T_LOAD, n);
         expect_reg("R2 count loaded", T_CNT, n);
         wr(T_CTL, ctl_word(1, 1, 0, 0, p));
         meas(per);
         check("R2 R4 period", per, exp_period(n, p));
      end

      // R4 tick_en gating
      wr(T_CTL, ctl_word(1, 1, 0, 0, 0));
      tick_en = 1'b0;
      wr(T_LOAD, 200);
      repeat (10) @(negedge clk);
      expect_reg("R4 hold without tick", T_CNT, 200);
      tick_en = 1'b1;
      repeat (10) @(negedge clk);
      expect_reg("R4 ten steps", T_CNT, 190);

      // R5 flag without enable, R3 one-shot hold
      wr(T_CTL, 0);
      wr(T_FLAG, 1);
      wr(T_LOAD, 4);
      wr(T_CTL, ctl_word(1, 0, 0, 0, 0));
      repeat (20) @(negedge clk);
      expect_reg("R5 flag set", T_FLAG, 1);
      check("R5 irq masked", tmr_irq, 0);
      expect_reg("R3 parked at zero", T_CNT, 0);
      wr(T_FLAG, 1);
      repeat (20) @(negedge clk);
      expect_reg("R3 no second event", T_FLAG, 0);
      expect_reg("R3 still zero", T_CNT, 0);

      // R5 exact interrupt timing
      wr(T_CTL, ctl_word(1, 0, 1, 0, 0));
      wr(T_LOAD, 3);
      repeat (2) @(negedge clk);
      check("R5 irq not yet", tmr_irq, 0);
      @(negedge clk);
      check("R5 irq on zero", tmr_irq, 1);
      wr(T_FLAG, 1);
      check("R5 irq cleared", tmr_irq, 0);

      // R11 timer has no watchdog bit
      wr(T_CTL, 32'h0000_0008);
      expect_reg("R11 tmr bit3", T_CTL, 0);

      // R6 watchdog fire
      wr(W_LOAD, 3);
      wr(W_CTL, ctl_word(1, 0, 1, 1, 0));
      pulses = 0; pulse_at = 0; wirq_seen = 0;
      for (int i = 1; i <= 10; i++) begin
         @(negedge clk);
         if (rst_req) begin pulses++; pulse_at = i; end
         if (wdt_irq) wirq_seen++;
      end
      check("R6 one pulse", pulses, 1);
      check("R6 pulse cycle", pulse_at, 3);
      check("R6 irq ignored", wirq_seen, 0);
      expect_reg("R6 cause set", W_CAUSE, 1);
      expect_reg("R6 flag untouched", W_FLAG, 0);

      // R10 cause persistence
      repeat (10) @(negedge clk);
      expect_reg("R10 cause kept", W_CAUSE, 1);
      wr(W_CAUSE, 0);
      expect_reg("R10 write 0 no effect", W_CAUSE, 1);
      wr(W_CAUSE, 1);
      expect_reg("R10 write 1 clears", W_CAUSE, 0);

      // R8 ways that must not leave watchdog mode
      wr(W_CTL, ctl_word(1, 0, 0, 0, 0));
      rd(W_CTL, v);
      check("R8 direct clear ignored", v[3], 1);
      wr(W_DIS, KA);
      wr(T_LOAD, 5);
      wr(W_DIS, KB);
      rd(W_CTL, v);
      check("R8 broken sequence", v[3], 1);
      wr(W_DIS, KB);
      rd(W_CTL, v);
      check("R8 second key alone", v[3], 1);

      // R7 proper exit
      wr(W_DIS, KA);
      wr(W_DIS, KB);
      rd(W_CTL, v);
      check("R7 key pair clears", v[3], 0);

      // R9 arm word, R11 readback
      wr(W_DIS, 1);
      rd(W_CTL, v);
      check("R9 arm word sets", v[3], 1);
      expect_reg("R11 disarm reads 0", W_DIS, 0);

      // R5 watchdog channel as a plain timer
      wr(W_DIS, KA);
      wr(W_DIS, KB);
      wr(W_LOAD, 2);
      wr(W_CTL, ctl_word(1, 0, 1, 0, 0));
      pulses = 0;
      for (int i = 1; i <= 5; i++) begin
         @(negedge clk);
         if (rst_req) pulses++;
      end
      check("R5 wd timer irq", wdt_irq, 1);
      check("R6 no reset in timer mode", pulses, 0);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule